// File: doc/BRIEF.md
# Memory-Operand Rotate Sequencer

This block is the control sequencer for the prefixed rotate and shift instructions whose operand lives in memory. After a one-cycle start request it fetches the instruction bytes over a byte-wide bus. It detects whether the operand is addressed through the HL pointer or through IX or IY plus a signed displacement, and then forms the effective address. It reads the operand, passes it through a rotate unit and writes the result back to the same address. Every clock is one T-state. Exactly one of four bus strobes (fetch, read, write, internal) is high on every T-state of an instruction.

The register values (HL, IX, IY), the incoming carry flag and the address of the first instruction byte are sampled on the start cycle. The block then counts its own fetch address upward. A byte that does not fit either instruction form ends the instruction at once with an illegal-opcode pulse, and no write cycle follows. A legal instruction ends with a completion pulse on the final T-state of its write cycle. The updated flags are presented on `flag_o`.

Top module: `mem_rotate_seq`

## Requirements
- R1: After reset, and whenever no instruction is running, `busy_o`, `done_o`, `illegal_o` and all four strobes are low.
- R2: A first byte 8'hCB followed by an operation byte with bits [7:6]=00 and [2:0]=110 runs 15 T-states: fetch 4, fetch 4, operand read 4, write 3.
- R3: A first byte 8'hDD (IX) or 8'hFD (IY), then 8'hCB, a displacement byte and an operation byte runs 23 T-states: fetch 4, fetch 4, displacement read 3, a 5-state cycle with fetch strobe on its first 3 states (operation byte) and internal strobe on its last 2, operand read 4, write 3.
- R4: The operand read and the write use HL in the first form, and IX or IY plus the displacement sign-extended to 16 bits, modulo 2^16, in the second.
- R5: Instruction bytes are fetched from consecutive addresses starting at `pc_i`, and each byte is sampled on the last T-state of its cycle (the third state of the 5-state cycle).
- R6: Operation bits [5:3] select the result: 000 rotate left circular, 001 rotate right circular, 010 rotate left through carry, 011 rotate right through carry, 100 shift left filling 0, 101 arithmetic shift right, 110 shift left filling 1, 111 logical shift right. The result is driven on `data_o` during the write cycle.
- R7: `flag_o` = {S,Z,H,PV,N,C}: S is result bit 7, Z is set when the result is zero, H=0, PV is set for even result parity, N=0, and C is the bit shifted out (bit 7 for left, bit 0 for right).
- R8: `done_o` pulses for one T-state, on the last state of the write cycle, and `busy_o` is low on the next state.
- R9: An operation byte that does not match 00xxx110 raises `illegal_o` on the T-state it is sampled, no write cycle follows, and the block is idle on the next state.
- R10: A first byte other than 8'hCB, 8'hDD or 8'hFD, or a second byte other than 8'hCB in the indexed form, raises `illegal_o` in the same way, with no write.
- R11: While an instruction runs, exactly one strobe is high on every T-state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one T-state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin an instruction (sampled while idle) |
| pc_i | input | 16 | Address of the first instruction byte |
| hl_i | input | 16 | HL pointer value |
| ix_i | input | 16 | IX index value |
| iy_i | input | 16 | IY index value |
| carry_i | input | 1 | Incoming carry flag |
| data_i | input | 8 | Read data bus |
| addr_o | output | 16 | Bus address |
| data_o | output | 8 | Write data (valid while write_o) |
| fetch_o | output | 1 | Instruction fetch strobe |
| read_o | output | 1 | Memory read strobe |
| write_o | output | 1 | Memory write strobe |
| intl_o | output | 1 | Internal (no bus) strobe |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Illegal byte pulse |
| flag_o | output | 6 | Flags {S,Z,H,PV,N,C} |

## Verification
The assertions check the strobe discipline on every cycle. One strobe is high while busy and none while idle. They also check that completion falls only on a write state and is followed by idle, that an illegal byte returns the block to idle, that the write address holds still, and that the T-state counter stays within the current cycle's length. Only the bench scenarios can show the exact order and lengths of the machine cycles for each form, the effective-address arithmetic (including wrap), the fetch addresses, and the result and flag values for each of the eight operations with both carry values.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] PFX_ROT = 8'hCB;
    localparam logic [BYTE_W-1:0] PFX_IXB = 8'hDD;
    localparam logic [BYTE_W-1:0] PFX_IYB = 8'hFD;

    localparam int SB_FETCH = 0;
    localparam int SB_READ  = 1;
    localparam int SB_WRITE = 2;
    localparam int SB_INTL  = 3;
    localparam int SB_NUM   = 4;

    // first 3 states of the 5-state cycle fetch the operation byte
    localparam logic [2:0] OPIX_FETCH_STATES = 3'd3;

    typedef enum logic [1:0] {FM_NONE, FM_HL, FM_IX, FM_IY} form_e;

    typedef enum logic [2:0] {CY_FETCH, CY_READ, CY_DISP, CY_OPIX, CY_WRITE} cyc_e;

    typedef struct packed {
        cyc_e       kind;
        logic [2:0] len;
    } cyc_t;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    function automatic logic is_indexed(form_e f);
        return (f == FM_IX) || (f == FM_IY);
    endfunction

    function automatic logic op_ok(logic [BYTE_W-1:0] b);
        return (b[7:6] == 2'b00) && (b[2:0] == 3'b110);
    endfunction

    // machine-cycle table: kind and T-state count per form and cycle index
    function automatic cyc_t cyc_of(form_e f, logic [2:0] m);
        cyc_t d;
        d.kind = CY_FETCH;
        d.len  = 3'd4;
        if (m >= 3'd2) begin
            if (!is_indexed(f)) begin
                if (m == 3'd2) begin
                    d.kind = CY_READ;  d.len = 3'd4;
                end else begin
                    d.kind = CY_WRITE; d.len = 3'd3;
                end
            end else begin
                case (m)
                    3'd2:    begin d.kind = CY_DISP;  d.len = 3'd3; end
                    3'd3:    begin d.kind = CY_OPIX;  d.len = 3'd5; end
                    3'd4:    begin d.kind = CY_READ;  d.len = 3'd4; end
                    default: begin d.kind = CY_WRITE; d.len = 3'd3; end
                endcase
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/rs_rotate.sv
module rs_rotate
    import rs_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] val_i,
    input  logic [2:0]   op_i,
    input  logic         carry_i,
    output logic [W-1:0] res_o,
    output flags_t       flags_o
);

    logic out_bit;

    always_comb begin
        case (op_i)
            3'b000: begin res_o = {val_i[W-2:0], val_i[W-1]};  out_bit = val_i[W-1]; end
            3'b001: begin res_o = {val_i[0], val_i[W-1:1]};    out_bit = val_i[0];   end
            3'b010: begin res_o = {val_i[W-2:0], carry_i};     out_bit = val_i[W-1]; end
            3'b011: begin res_o = {carry_i, val_i[W-1:1]};     out_bit = val_i[0];   end
            3'b100: begin res_o = {val_i[W-2:0], 1'b0};        out_bit = val_i[W-1]; end
            3'b101: begin res_o = {val_i[W-1], val_i[W-1:1]};  out_bit = val_i[0];   end
            3'b110: begin res_o = {val_i[W-2:0], 1'b1};        out_bit = val_i[W-1]; end
            default: begin res_o = {1'b0, val_i[W-1:1]};       out_bit = val_i[0];   end
        endcase
        flags_o.s  = res_o[W-1];
        flags_o.z  = (res_o == '0);
        flags_o.h  = 1'b0;
        flags_o.pv = ~^res_o;
        flags_o.n  = 1'b0;
        flags_o.c  = out_bit;
    end

endmodule

// File: rtl/rs_ea.sv
module rs_ea
    import rs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  form_e              form_i,
    input  logic [ADDR_W-1:0]  hl_i,
    input  logic [ADDR_W-1:0]  ix_i,
    input  logic [ADDR_W-1:0]  iy_i,
    input  logic [BYTE_W-1:0]  disp_i,
    output logic [ADDR_W-1:0]  ea_o
);

    localparam int EXT_W = ADDR_W - BYTE_W;

    logic [ADDR_W-1:0] disp_x;
    logic [ADDR_W-1:0] base;

    assign disp_x = {{EXT_W{disp_i[BYTE_W-1]}}, disp_i};

    always_comb begin
        case (form_i)
            FM_IX:   base = ix_i;
            FM_IY:   base = iy_i;
            default: base = hl_i;
        endcase
        ea_o = is_indexed(form_i) ? (base + disp_x) : base;
    end

endmodule

// File: rtl/rs_strobe.sv
module rs_strobe
    import rs_pkg::*;
(
    input  cyc_e              kind_i,
    input  logic [2:0]        tst_i,
    input  logic              act_i,
    output logic [SB_NUM-1:0] stb_o
);

    always_comb begin
        stb_o = '0;
        if (act_i) begin
            case (kind_i)
                CY_FETCH: stb_o[SB_FETCH] = 1'b1;
                CY_READ,
                CY_DISP:  stb_o[SB_READ]  = 1'b1;
                CY_WRITE: stb_o[SB_WRITE] = 1'b1;
                default: begin
                    if (tst_i < OPIX_FETCH_STATES) stb_o[SB_FETCH] = 1'b1;
                    else                           stb_o[SB_INTL]  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/mem_rotate_seq.sv
module mem_rotate_seq
    import rs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] hl_i,
    input  logic [ADDR_W-1:0] ix_i,
    input  logic [ADDR_W-1:0] iy_i,
    input  logic              carry_i,
    input  logic [7:0]        data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o,
    output logic              fetch_o,
    output logic              read_o,
    output logic              write_o,
    output logic              intl_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              illegal_o,
    output logic [5:0]        flag_o
);

    logic              busy_q;
    form_e             form_q;
    logic [2:0]        m_q;
    logic [2:0]        t_q;
    logic [ADDR_W-1:0] pc_q, hl_q, ix_q, iy_q, ea_q;
    logic              carry_q;
    logic [7:0]        disp_q, op_q, res_q;
    flags_t            flags_q;

    cyc_t              desc;
    logic              last_t, sample, fetchish, bad;
    logic [ADDR_W-1:0] ea_calc;
    logic [7:0]        alu_res;
    flags_t            alu_flags;
    logic [SB_NUM-1:0] stb;

    assign desc = cyc_of(form_q, m_q);

    always_comb begin
        last_t   = (t_q == desc.len - 3'd1);
        fetchish = (desc.kind == CY_FETCH) || (desc.kind == CY_DISP) || (desc.kind == CY_OPIX);
        if (desc.kind == CY_OPIX) sample = busy_q && (t_q == OPIX_FETCH_STATES - 3'd1);
        else                      sample = busy_q && (desc.kind != CY_WRITE) && last_t;
        case (m_q)
            3'd0:    bad = !((data_i == PFX_ROT) || (data_i == PFX_IXB) || (data_i == PFX_IYB));
            3'd1:    bad = is_indexed(form_q) ? (data_i != PFX_ROT) : !op_ok(data_i);
            3'd3:    bad = is_indexed(form_q) && !op_ok(data_i);
            default: bad = 1'b0;
        endcase
    end

    rs_ea #(.ADDR_W(ADDR_W)) u_ea (
        .form_i (form_q),
        .hl_i   (hl_q),
        .ix_i   (ix_q),
        .iy_i   (iy_q),
        .disp_i (disp_q),
        .ea_o   (ea_calc)
    );

    rs_rotate #(.W(BYTE_W)) u_rot (
        .val_i   (data_i),
        .op_i    (op_q[5:3]),
        .carry_i (carry_q),
        .res_o   (alu_res),
        .flags_o (alu_flags)
    );

    rs_strobe u_stb (
        .kind_i (desc.kind),
        .tst_i  (t_q),
        .act_i  (busy_q),
        .stb_o  (stb)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            form_q  <= FM_NONE;
            m_q     <= '0;
            t_q     <= '0;
            pc_q    <= '0;
            hl_q    <= '0;
            ix_q    <= '0;
            iy_q    <= '0;
            ea_q    <= '0;
            carry_q <= 1'b0;
            disp_q  <= '0;
            op_q    <= '0;
            res_q   <= '0;
            flags_q <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q  <= 1'b1;
                form_q  <= FM_NONE;
                m_q     <= '0;
                t_q     <= '0;
                pc_q    <= pc_i;
                hl_q    <= hl_i;
                ix_q    <= ix_i;
                iy_q    <= iy_i;
                carry_q <= carry_i;
            end
        end else begin
            if (sample && fetchish) pc_q <= pc_q + 1'b1;

            if (sample && (m_q == 3'd0)) begin
                case (data_i)
                    PFX_IXB: form_q <= FM_IX;
                    PFX_IYB: form_q <= FM_IY;
                    default: form_q <= FM_HL;
                endcase
            end

            if (sample && (((m_q == 3'd1) && !is_indexed(form_q)) ||
                           ((m_q == 3'd3) && is_indexed(form_q))))
                op_q <= data_i;

            if (sample && (desc.kind == CY_DISP)) disp_q <= data_i;

            if (last_t && (((m_q == 3'd1) && !is_indexed(form_q)) ||
                           ((m_q == 3'd3) && is_indexed(form_q))))
                ea_q <= ea_calc;

            if (sample && (desc.kind == CY_READ)) begin
                res_q   <= alu_res;
                flags_q <= alu_flags;
            end

            if ((sample && bad) || (desc.kind == CY_WRITE && last_t)) begin
                busy_q <= 1'b0;
                m_q    <= '0;
                t_q    <= '0;
            end else if (last_t) begin
                t_q <= '0;
                m_q <= m_q + 3'd1;
            end else begin
                t_q <= t_q + 3'd1;
            end
        end
    end

    assign addr_o    = fetchish ? pc_q : ea_q;
    assign data_o    = res_q;
    assign fetch_o   = stb[SB_FETCH];
    assign read_o    = stb[SB_READ];
    assign write_o   = stb[SB_WRITE];
    assign intl_o    = stb[SB_INTL];
    assign busy_o    = busy_q;
    assign done_o    = busy_q && (desc.kind == CY_WRITE) && last_t;
    assign illegal_o = sample && bad;
    assign flag_o    = flags_q;

    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ($countones({fetch_o, read_o, write_o, intl_o}) == 1)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> ({fetch_o, read_o, write_o, intl_o, done_o, illegal_o} == 6'b0)); // R1
    AST_DONE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        done_o |-> write_o); // R8
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o)); // R8
    AST_ILLEGAL_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        illegal_o |=> (!busy_o && !write_o)); // R9
    AST_WRITE_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (write_o && $past(write_o)) |-> $stable(addr_o)); // R4
    AST_TSTATE_BOUND: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (t_q < desc.len)); // R2

endmodule

// File: tb/mem_rotate_seq_tb.sv
module mem_rotate_seq_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i;
    logic [15:0] pc_i, hl_i, ix_i, iy_i;
    logic        carry_i;
    logic [7:0]  data_i;
    logic [15:0] addr_o;
    logic [7:0]  data_o;
    logic        fetch_o, read_o, write_o, intl_o, busy_o, done_o, illegal_o;
    logic [5:0]  flag_o;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  prog [0:3];
    int          plen;
    logic [15:0] exp_ea;
    logic [7:0]  operand;
    logic [15:0] off;

    always #4 clk = ~clk;

    mem_rotate_seq u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .pc_i(pc_i), .hl_i(hl_i),
        .ix_i(ix_i), .iy_i(iy_i), .carry_i(carry_i), .data_i(data_i),
        .addr_o(addr_o), .data_o(data_o), .fetch_o(fetch_o), .read_o(read_o),
        .write_o(write_o), .intl_o(intl_o), .busy_o(busy_o), .done_o(done_o),
        .illegal_o(illegal_o), .flag_o(flag_o)
    );

    // bus model: program bytes at pc_i.., operand at the expected address
    assign off = addr_o - pc_i;
    always_comb begin
        data_i = 8'h00;
        if (fetch_o || read_o) begin
            if (off < 16'(plen))        data_i = prog[off[1:0]];
            else if (addr_o == exp_ea)  data_i = operand;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] ref_rot(input logic [7:0] v, input logic [2:0] op, input logic c);
        logic [7:0] r;
        logic       co;
        case (op)
            3'd0: begin r = {v[6:0], v[7]}; co = v[7]; end
            3'd1: begin r = {v[0], v[7:1]}; co = v[0]; end
            3'd2: begin r = {v[6:0], c};    co = v[7]; end
            3'd3: begin r = {c, v[7:1]};    co = v[0]; end
            3'd4: begin r = {v[6:0], 1'b0}; co = v[7]; end
            3'd5: begin r = {v[7], v[7:1]}; co = v[0]; end
            3'd6: begin r = {v[6:0], 1'b1}; co = v[7]; end
            default: begin r = {1'b0, v[7:1]}; co = v[0]; end
        endcase
        return {co, r};
    endfunction

    // 1 fetch, 2 read, 3 write, 4 internal
    function automatic int exp_code(input logic idx, input int k);
        if (!idx) begin
            if (k < 8) return 1;
            if (k < 12) return 2;
            return 3;
        end
        if (k < 8)  return 1;
        if (k < 11) return 2;
        if (k < 14) return 1;
        if (k < 16) return 4;
        if (k < 20) return 2;
        return 3;
    endfunction

    task automatic run(input logic [7:0] b0, b1, b2, b3, input int nb,
                       input logic [7:0] opnd, input logic c, input int ill_at);
        logic        idx;
        logic [7:0]  opb;
        logic [8:0]  rr;
        logic [5:0]  ef;
        int          seq_bad, wr_cnt, done_cnt, done_at, ill_seen, code, total;
        logic [15:0] wa;
        logic [7:0]  wd;
        logic [15:0] ra;
        logic [15:0] fa [0:3];
        idx = (b0 == 8'hDD) || (b0 == 8'hFD);
        opb = idx ? b3 : b1;
        prog[0] = b0; prog[1] = b1; prog[2] = b2; prog[3] = b3;
        plen = nb; operand = opnd; carry_i = c;
        if (b0 == 8'hDD)      exp_ea = ix_i + {{8{b2[7]}}, b2};
        else if (b0 == 8'hFD) exp_ea = iy_i + {{8{b2[7]}}, b2};
        else                  exp_ea = hl_i;
        seq_bad = 0; wr_cnt = 0; done_cnt = 0; done_at = -1; ill_seen = -1; total = 0;
        wa = '0; wd = '0; ra = '0;
        for (int i = 0; i < 4; i++) fa[i] = '0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 0; k < 40; k++) begin
            case ({fetch_o, read_o, write_o, intl_o})
                4'b1000: code = 1;
                4'b0100: code = 2;
                4'b0010: code = 3;
                4'b0001: code = 4;
                default: code = 9;
            endcase
            if (code != exp_code(idx, k)) seq_bad++;
            if (k == 0)  fa[0] = addr_o;
            if (k == 4)  fa[1] = addr_o;
            if (k == 8)  fa[2] = addr_o;
            if (k == 11) fa[3] = addr_o;
            if (read_o && (k == (idx ? 19 : 11))) ra = addr_o;
            if (write_o) begin wr_cnt++; wa = addr_o; wd = data_o; end
            if (done_o)  begin done_cnt++; done_at = k; ef = flag_o; end
            if (illegal_o) ill_seen = k;
            total = k + 1;
            if (done_o || illegal_o) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(!busy_o, "R8/R9 idle after end", busy_o, 0);
        chk(fa[0] == pc_i, "R5 first fetch addr", fa[0], pc_i);
        if (ill_at >= 0) begin
            chk(ill_seen == ill_at, "R9/R10 illegal pulse cycle", ill_seen, ill_at);
            chk(wr_cnt == 0 && done_cnt == 0, "R9/R10 no write on illegal", wr_cnt, 0);
            chk(seq_bad == 0, "R11 strobe pattern before abort", seq_bad, 0);
        end else begin
            rr = ref_rot(opnd, opb[5:3], c);
            chk(seq_bad == 0, idx ? "R3 cycle pattern" : "R2 cycle pattern", seq_bad, 0);
            chk(total == (idx ? 23 : 15), idx ? "R3 T-state count" : "R2 T-state count", total, idx ? 23 : 15);
            chk(fa[1] == pc_i + 16'd1, "R5 second fetch addr", fa[1], pc_i + 16'd1);
            if (idx) begin
                chk(fa[2] == pc_i + 16'd2, "R5 displacement addr", fa[2], pc_i + 16'd2);
                chk(fa[3] == pc_i + 16'd3, "R5 op byte addr", fa[3], pc_i + 16'd3);
            end
            chk(ra == exp_ea, "R4 read addr", ra, exp_ea);
            chk(wr_cnt == 3 && wa == exp_ea, "R4 write addr", wa, exp_ea);
            chk(wd == rr[7:0], "R6 result", wd, rr[7:0]);
            chk(ef == {rr[7], rr[7:0] == 8'h00, 1'b0, ~^rr[7:0], 1'b0, rr[8]}, "R7 flags", ef,
                {rr[7], rr[7:0] == 8'h00, 1'b0, ~^rr[7:0], 1'b0, rr[8]});
            chk(done_cnt == 1 && done_at == total - 1, "R8 done pulse", done_at, total - 1);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; start_i = 1'b0; pc_i = 16'hC000; hl_i = 16'h1234;
        ix_i = 16'h2000; iy_i = 16'h3000; carry_i = 1'b0;
        plen = 0; exp_ea = 16'h0000; operand = 8'h00;
        for (int i = 0; i < 4; i++) prog[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, illegal_o, fetch_o, read_o, write_o, intl_o} == 7'b0, "R1 in reset",
            {busy_o, done_o, illegal_o, fetch_o, read_o, write_o, intl_o}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk({busy_o, done_o, illegal_o, fetch_o, read_o, write_o, intl_o} == 7'b0, "R1 idle",
            {busy_o, done_o, illegal_o, fetch_o, read_o, write_o, intl_o}, 0);

        // every operation, both carry values, register-indirect form (R6 R7)
        for (int o = 0; o < 8; o++) begin
            run(8'hCB, {2'b00, 3'(o), 3'b110}, 8'h00, 8'h00, 2, 8'h81, 1'b1, -1);
            run(8'hCB, {2'b00, 3'(o), 3'b110}, 8'h00, 8'h00, 2, 8'h80, 1'b0, -1);
        end
        // zero result and sign cases (R7)
        run(8'hCB, 8'h3E, 8'h00, 8'h00, 2, 8'h01, 1'b0, -1);
        run(8'hCB, 8'h2E, 8'h00, 8'h00, 2, 8'hC0, 1'b0, -1);
        // indexed: IX negative displacement, IY positive, wrap both ways (R3 R4)
        ix_i = 16'h4000; run(8'hDD, 8'hCB, 8'hF0, 8'h06, 4, 8'h5A, 1'b0, -1);
        iy_i = 16'h5000; run(8'hFD, 8'hCB, 8'h7F, 8'h16, 4, 8'hA5, 1'b1, -1);
        ix_i = 16'h0005; run(8'hDD, 8'hCB, 8'h80, 8'h0E, 4, 8'h01, 1'b0, -1);
        iy_i = 16'hFFF0; run(8'hFD, 8'hCB, 8'h20, 8'h1E, 4, 8'h02, 1'b1, -1);
        // illegal cases (R9 R10)
        run(8'hCB, 8'h47, 8'h00, 8'h00, 2, 8'h11, 1'b0, 7);
        run(8'hCB, 8'h86, 8'h00, 8'h00, 2, 8'h11, 1'b0, 7);
        run(8'hDD, 8'hCB, 8'h05, 8'h07, 4, 8'h11, 1'b0, 13);
        run(8'h00, 8'h00, 8'h00, 8'h00, 1, 8'h11, 1'b0, 3);
        run(8'hFD, 8'h00, 8'h00, 8'h00, 2, 8'h11, 1'b0, 7);
        // constrained random
        for (int n = 0; n < 60; n++) begin
            int          f;
            logic [7:0]  opb, d;
            f   = int'($urandom % 3);
            opb = {2'b00, 3'($urandom % 8), 3'b110};
            d   = 8'($urandom);
            pc_i = 16'hC000 + 16'($urandom % 64);
            hl_i = 16'($urandom % 32'hBF00);
            ix_i = 16'($urandom) & 16'h7FFF;
            iy_i = 16'($urandom) & 16'h7FFF;
            if (f == 0)      run(8'hCB, opb, 8'h00, 8'h00, 2, 8'($urandom), 1'($urandom), -1);
            else if (f == 1) run(8'hDD, 8'hCB, d, opb, 4, 8'($urandom), 1'($urandom), -1);
            else             run(8'hFD, 8'hCB, d, opb, 4, 8'($urandom), 1'($urandom), -1);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule